// File: doc/BRIEF.md
# Table-Driven Sine and Cosine Generator

This block turns a phase word into a pair of signed sine and cosine samples without any rotation iterations. The upper phase bits pick a quadrant and an entry in a small table of first-quadrant values. The low phase bits give a small residual angle, and that residual refines both table values through a first-order correction. The correction is built only from shifted copies and additions, so no multiplier is needed.

The block is a two-register pipeline. A phase presented with its valid strobe on one clock edge gives a sample pair two edges later, and a new phase can be accepted on every cycle. It sits behind a phase source such as a numerically controlled oscillator. Typical users are mixers and test-tone paths that need both outputs at once.

Top module: `lut_sincos`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by exactly two clock cycles, and a new phase is accepted on every cycle that `in_vld` is high, with no bubbles.
- R2: While `rst` (active high, synchronous) is high, the next clock edge forces `out_vld` low and both data outputs to 0. A phase offered during reset never produces a valid output.
- R3: The phase angle is `in_phase`·2π/65536. Bits [15:14] are the quadrant, bits [13:8] are the 6-bit table index, and bits [7:0] are the residual.
- R4: For every one of the 65536 phase codes, `out_sin` is within 4 LSB of round(32768·sin θ) clipped to ±32767.
- R5: For every phase code, `out_cos` is within 4 LSB of round(32768·cos θ) clipped to ±32767.
- R6: In quadrant 0 (phase bits [15:14] = 00) both outputs are ≥ 0. In quadrant 2 (bits = 10) both outputs are ≤ 0.
- R7: Neither output ever takes the value −32768. Magnitudes saturate at 32767, so a full-scale result of +1.0 or −1.0 never wraps.
- R8: On a cycle where `out_vld` is low, `out_sin` and `out_cos` keep the values of the last valid sample, or 0 if there has been none since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Phase word is valid this cycle |
| in_phase | input | 16 | Phase: quadrant, table index, residual |
| out_vld | output | 1 | Sample pair is valid this cycle |
| out_sin | output | 16 | Signed sine sample, scale 32768 = 1.0 |
| out_cos | output | 16 | Signed cosine sample, scale 32768 = 1.0 |

## Verification
A wrong table entry shows up two cycles after its phase is presented. It appears as an error spike across one 256-code band of residuals, seen in sine for one index and in cosine for the mirrored index, in every quadrant. A wrong residual weight or sign makes the error grow toward both edges of every band rather than staying near the midpoint. A quadrant-mapping fault flips or swaps whole quarters of the sweep. A pipeline valid fault appears as a missing or extra `out_vld`, or as data moving on an idle cycle, exactly two cycles after the offending input. A full ascending sweep, a gapped sweep with stride and the quadrant corners cover these cases.

// File: rtl/sc_pkg.sv
package sc_pkg;

   // quadrant selected by the two most significant phase bits
   typedef enum logic [1:0] {
      QD_0   = 2'd0,
      QD_90  = 2'd1,
      QD_180 = 2'd2,
      QD_270 = 2'd3
   } quad_e;

   localparam real PI_R = 3.14159265358979323846;

   // first-quadrant sine at the centre of table slot idx, scaled by 2**frac_w
   function automatic int table_value(int idx, int addr_w, int frac_w);
      real slot;
      real ang;
      slot = (PI_R / 2.0) / real'(1 << addr_w);
      ang  = (real'(idx) + 0.5) * slot;
      return $rtoi($sin(ang) * real'(1 << frac_w) + 0.5);
   endfunction

endpackage

// File: rtl/sc_rom.sv
module sc_rom #(
   parameter int ADDR_W = 6,
   parameter int VAL_W  = 20
) (
   input  logic [ADDR_W-1:0] idx_i,
   output logic [VAL_W-1:0]  sin_o,
   output logic [VAL_W-1:0]  cos_o
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int FRAC_W = VAL_W - 1;

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
      $error("sc_rom: ADDR_W out of range");
   end
   if (VAL_W > 30) begin : g_bad_val
      $error("sc_rom: VAL_W too wide for table generation");
   end

   logic [VAL_W-1:0] tbl [DEPTH];

   // table contents are computed at elaboration, one slot per generate pass
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam int ENT = sc_pkg::table_value(i, ADDR_W, FRAC_W);
      assign tbl[i] = VAL_W'(ENT);
   end

   // midpoint slots are mirror images: cos of slot i equals sin of slot (DEPTH-1-i)
   assign sin_o = tbl[idx_i];
   assign cos_o = tbl[~idx_i];

endmodule

// File: rtl/sc_shift_mul.sv
module sc_shift_mul #(
   parameter int RES_W = 8,
   parameter int VAL_W = 20,
   parameter int DROP  = 15
) (
   input  logic signed [RES_W-1:0] rs_i,    // residual offset from slot centre
   input  logic        [VAL_W-1:0] val_i,   // non-negative table value
   output logic signed [VAL_W-1:0] corr_o   // rs * val * pi / 2**DROP
);
   // pi * 4096 ~= 12868 = 2^13 + 2^12 + 2^9 + 2^6 + 2^2
   localparam int PI_FRAC = 12;
   localparam int NPI     = 5;
   localparam int PI_SH [NPI] = '{13, 12, 9, 6, 2};
   localparam int PW      = VAL_W + RES_W + PI_FRAC + 4;
   localparam int SH      = DROP + PI_FRAC;
   localparam logic signed [PW-1:0] RND = {{(PW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};

   if (SH >= PW) begin : g_bad_drop
      $error("sc_shift_mul: DROP too large for product width");
   end

   logic signed [PW-1:0] ext;
   logic signed [PW-1:0] racc;
   logic signed [PW-1:0] pacc;

   assign ext = PW'(val_i);

   always_comb begin
      // residual times value: one shifted copy per set residual bit
      racc = '0;
      for (int k = 0; k < RES_W - 1; k++) begin
         if (rs_i[k]) racc = racc + (ext <<< k);
      end
      if (rs_i[RES_W-1]) racc = racc - (ext <<< (RES_W - 1));
      // radian weight: multiply by pi with a fixed shift set
      pacc = '0;
      for (int j = 0; j < NPI; j++) begin
         pacc = pacc + (racc <<< PI_SH[j]);
      end
      corr_o = VAL_W'((pacc + RND) >>> SH);
   end

endmodule

// File: rtl/sc_quad_map.sv
module sc_quad_map #(
   parameter int OUT_W = 16,
   parameter int GUARD = 4
) (
   input  sc_pkg::quad_e                quad_i,
   input  logic signed [OUT_W+GUARD:0]  fs_i,   // first-quadrant sine, guard scale
   input  logic signed [OUT_W+GUARD:0]  fc_i,   // first-quadrant cosine, guard scale
   output logic signed [OUT_W-1:0]      sin_o,
   output logic signed [OUT_W-1:0]      cos_o
);
   localparam int FW = OUT_W + GUARD + 1;
   localparam logic signed [FW-1:0] HALF = FW'(1 << (GUARD - 1));
   localparam logic signed [FW-1:0] TOPF = FW'((1 << (OUT_W - 1)) - 1);

   if (GUARD < 1) begin : g_bad_guard
      $error("sc_quad_map: GUARD must be at least 1");
   end

   // round away the guard bits, clamp to [0, +full scale]
   function automatic logic signed [OUT_W-1:0] fold(input logic signed [FW-1:0] x);
      logic signed [FW-1:0] r;
      r = (x + HALF) >>> GUARD;
      if (r < 0)         return '0;
      else if (r > TOPF) return TOPF[OUT_W-1:0];
      else               return r[OUT_W-1:0];
   endfunction

   logic signed [OUT_W-1:0] ms;
   logic signed [OUT_W-1:0] mc;

   always_comb begin
      ms = fold(fs_i);
      mc = fold(fc_i);
      case (quad_i)
         sc_pkg::QD_0: begin
            sin_o = ms;
            cos_o = mc;
         end
         sc_pkg::QD_90: begin
            sin_o = mc;
            cos_o = -ms;
         end
         sc_pkg::QD_180: begin
            sin_o = -ms;
            cos_o = -mc;
         end
         default: begin
            sin_o = -mc;
            cos_o = ms;
         end
      endcase
   end

endmodule

// File: rtl/lut_sincos.sv
module lut_sincos #(
   parameter int PHASE_W = 16,
   parameter int ADDR_W  = 6,
   parameter int OUT_W   = 16,
   parameter int GUARD   = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_vld,
   input  logic [PHASE_W-1:0]       in_phase,
   output logic                     out_vld,
   output logic signed [OUT_W-1:0]  out_sin,
   output logic signed [OUT_W-1:0]  out_cos
);
   localparam int RES_W = PHASE_W - 2 - ADDR_W;
   localparam int VAL_W = OUT_W + GUARD;
   localparam int DROP  = ADDR_W + RES_W + 1;
   localparam logic signed [VAL_W-1:0] CORR_MAX = VAL_W'(1 << (VAL_W - ADDR_W - 1));
   localparam logic signed [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};

   if (RES_W < 2) begin : g_bad_res
      $error("lut_sincos: phase too narrow for quadrant, index and residual");
   end
   if (OUT_W < 8) begin : g_bad_out
      $error("lut_sincos: OUT_W too small");
   end

   // ---------------- stage 1: table read ----------------
   logic [VAL_W-1:0] rom_sin;
   logic [VAL_W-1:0] rom_cos;

   sc_rom #(.ADDR_W(ADDR_W), .VAL_W(VAL_W)) u_rom (
      .idx_i (in_phase[PHASE_W-3 -: ADDR_W]),
      .sin_o (rom_sin),
      .cos_o (rom_cos)
   );

   logic                s1_vld;
   sc_pkg::quad_e       s1_q;
   logic [RES_W-1:0]    s1_res;
   logic [VAL_W-1:0]    s1_sin;
   logic [VAL_W-1:0]    s1_cos;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld <= 1'b0;
         s1_q   <= sc_pkg::QD_0;
         s1_res <= '0;
         s1_sin <= '0;
         s1_cos <= '0;
      end else begin
         s1_vld <= in_vld;
         if (in_vld) begin
            s1_q   <= sc_pkg::quad_e'(in_phase[PHASE_W-1 -: 2]);
            s1_res <= in_phase[RES_W-1:0];
            s1_sin <= rom_sin;
            s1_cos <= rom_cos;
         end
      end
   end

   // ---------------- stage 2: residual correction ----------------
   // residual measured from slot centre: flipping the top bit subtracts half range
   logic signed [RES_W-1:0] rs;
   assign rs = {~s1_res[RES_W-1], s1_res[RES_W-2:0]};

   logic signed [VAL_W-1:0] corr_sin;   // r * cos, added to sine
   logic signed [VAL_W-1:0] corr_cos;   // r * sin, taken from cosine

   sc_shift_mul #(.RES_W(RES_W), .VAL_W(VAL_W), .DROP(DROP)) u_mul_c (
      .rs_i   (rs),
      .val_i  (s1_cos),
      .corr_o (corr_sin)
   );

   sc_shift_mul #(.RES_W(RES_W), .VAL_W(VAL_W), .DROP(DROP)) u_mul_s (
      .rs_i   (rs),
      .val_i  (s1_sin),
      .corr_o (corr_cos)
   );

   logic signed [VAL_W:0] fs;
   logic signed [VAL_W:0] fc;
   assign fs = $signed({1'b0, s1_sin}) + (VAL_W+1)'(corr_sin);
   assign fc = $signed({1'b0, s1_cos}) - (VAL_W+1)'(corr_cos);

   logic signed [OUT_W-1:0] m_sin;
   logic signed [OUT_W-1:0] m_cos;

   sc_quad_map #(.OUT_W(OUT_W), .GUARD(GUARD)) u_map (
      .quad_i (s1_q),
      .fs_i   (fs),
      .fc_i   (fc),
      .sin_o  (m_sin),
      .cos_o  (m_cos)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld <= 1'b0;
         out_sin <= '0;
         out_cos <= '0;
      end else begin
         out_vld <= s1_vld;
         if (s1_vld) begin
            out_sin <= m_sin;
            out_cos <= m_cos;
         end
      end
   end

   // ---------------- assertions ----------------
   p_lat_r1: assert property (@(posedge clk) disable iff (rst)
      in_vld |-> ##2 out_vld);
   p_idle_r1: assert property (@(posedge clk) disable iff (rst)
      !in_vld |-> ##2 !out_vld);
   p_reset_r2: assert property (@(posedge clk)
      rst |=> (!out_vld && out_sin == '0 && out_cos == '0));
   p_corr_bound_r4: assert property (@(posedge clk) disable iff (rst)
      s1_vld |-> (corr_sin <= CORR_MAX && corr_sin >= -CORR_MAX &&
                  corr_cos <= CORR_MAX && corr_cos >= -CORR_MAX));
   p_sign_q0_r6: assert property (@(posedge clk) disable iff (rst)
      (s1_vld && s1_q == sc_pkg::QD_0) |=> (out_sin >= 0 && out_cos >= 0));
   p_sign_q2_r6: assert property (@(posedge clk) disable iff (rst)
      (s1_vld && s1_q == sc_pkg::QD_180) |=> (out_sin <= 0 && out_cos <= 0));
   p_no_min_r7: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (out_sin != NEG_FULL && out_cos != NEG_FULL));
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !s1_vld |=> ($stable(out_sin) && $stable(out_cos)));

endmodule

// File: tb/sim_lut_sincos.sv
module sim_lut_sincos;
   localparam int PW  = 16;
   localparam int OW  = 16;
   localparam int TOL = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;   // 100 MHz

   logic                 rst;
   logic                 in_vld;
   logic [PW-1:0]        in_phase;
   logic                 out_vld;
   logic signed [OW-1:0] out_sin;
   logic signed [OW-1:0] out_cos;

   lut_sincos u0 (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (in_vld),
      .in_phase (in_phase),
      .out_vld  (out_vld),
      .out_sin  (out_sin),
      .out_cos  (out_cos)
   );

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit            q_v  [$];
   logic [PW-1:0] q_ph [$];
   int  held_s = 0;
   int  held_c = 0;

   function automatic int ref_val(logic [PW-1:0] ph, bit want_cos);
      real th;
      real x;
      int  r;
      th = 2.0 * 3.14159265358979323846 * real'(ph) / 65536.0;
      x  = want_cos ? $cos(th) : $sin(th);
      r  = $rtoi($floor(x * 32768.0 + 0.5));
      if (r > 32767)  r = 32767;
      if (r < -32767) r = -32767;
      return r;
   endfunction

   function automatic int iabs(int a);
      return (a < 0) ? -a : a;
   endfunction

   task automatic chk(bit ok, string tag, int act, int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   // compare outputs against the phase driven two negedges earlier
   task automatic check_front();
      bit            v;
      logic [PW-1:0] ph;
      int            rs;
      int            rc;
      if (q_v.size() >= 2) begin
         v  = q_v.pop_front();
         ph = q_ph.pop_front();
         chk(out_vld == v, "R1 valid two cycles after input", int'(out_vld), int'(v));
         if (v) begin
            rs = ref_val(ph, 1'b0);
            rc = ref_val(ph, 1'b1);
            chk(iabs(int'(out_sin) - rs) <= TOL, "R3/R4 sine accuracy", int'(out_sin), rs);
            chk(iabs(int'(out_cos) - rc) <= TOL, "R5 cosine accuracy", int'(out_cos), rc);
            chk(int'(out_sin) != -32768 && int'(out_cos) != -32768,
                "R7 no negative full-scale code", int'(out_sin), rs);
            if (ph[15:14] == 2'b00)
               chk(out_sin >= 0 && out_cos >= 0, "R6 quadrant 0 signs", int'(out_sin), rs);
            if (ph[15:14] == 2'b10)
               chk(out_sin <= 0 && out_cos <= 0, "R6 quadrant 2 signs", int'(out_sin), rs);
            held_s = int'(out_sin);
            held_c = int'(out_cos);
         end else begin
            chk(int'(out_sin) == held_s, "R8 sine holds on idle", int'(out_sin), held_s);
            chk(int'(out_cos) == held_c, "R8 cosine holds on idle", int'(out_cos), held_c);
         end
      end
   endtask

   task automatic drive(bit v, logic [PW-1:0] ph);
      @(negedge clk);
      check_front();
      in_vld   = v;
      in_phase = ph;
      q_v.push_back(v);
      q_ph.push_back(ph);
   endtask

   initial begin
      rst      = 1'b1;
      in_vld   = 1'b0;
      in_phase = '0;
      repeat (3) @(negedge clk);
      chk(out_vld == 1'b0, "R2 reset clears valid", int'(out_vld), 0);
      chk(out_sin == '0, "R2 reset clears sine", int'(out_sin), 0);
      chk(out_cos == '0, "R2 reset clears cosine", int'(out_cos), 0);
      rst = 1'b0;

      // full ascending sweep, back to back (R1 throughput, R3..R7)
      for (int i = 0; i < 65536; i++) drive(1'b1, PW'(i));

      // strided sweep with idle gaps (R8 hold, R1 idle timing)
      for (int i = 0; i < 3000; i++) drive((i % 3) != 1, PW'(i * 997 + 311));

      // quadrant corners and slot edges
      drive(1'b1, 16'h0000);
      drive(1'b1, 16'h4000);
      drive(1'b1, 16'h8000);
      drive(1'b1, 16'hC000);
      drive(1'b1, 16'h3FFF);
      drive(1'b0, 16'h7777);
      drive(1'b1, 16'h7FFF);
      drive(1'b1, 16'hFFFF);
      drive(1'b1, 16'h0080);
      drive(1'b1, 16'h00FF);
      drive(1'b1, 16'h0100);
      drive(1'b0, 16'h2222);
      drive(1'b0, 16'h0000);
      drive(1'b0, 16'h0000);

      // R2: reset while a phase is offered; nothing escapes afterwards
      @(negedge clk);
      check_front();
      q_v.delete();
      q_ph.delete();
      in_vld   = 1'b1;
      in_phase = 16'h1234;
      rst      = 1'b1;
      @(negedge clk);
      chk(out_vld == 1'b0, "R2 reset during traffic clears valid", int'(out_vld), 0);
      chk(out_sin == '0 && out_cos == '0, "R2 reset during traffic clears data",
          int'(out_sin), 0);
      @(negedge clk);
      rst    = 1'b0;
      in_vld = 1'b0;
      @(negedge clk);
      chk(out_vld == 1'b0, "R2 phase offered in reset gives no output", int'(out_vld), 0);
      @(negedge clk);
      chk(out_vld == 1'b0, "R2 pipeline empty after reset", int'(out_vld), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule